// File: doc/BRIEF.md
# Vector Multiply Memory-to-Memory Coprocessor

This block takes one command at a time. A command names two operand vectors and a result vector in main memory, plus an element count. The block multiplies the operands element by element, z[i] = a[i] * b[i]. It never computes directly on main memory. It first copies both operand vectors into a private local buffer through a single-port memory master. It then runs the multiplier over that buffer and copies the products back out through the same port.

The work runs as a fixed sequence of stages, and each stage finishes before the next one starts:

1. Decode: the command is decoded and the element count is clamped.
2. Fetch: the operands are brought in by DMA.
3. Compute: the products are formed inside the buffer.
4. Setup: the result count and destination pointer are set up.
5. Drain: the results are written back by DMA.

A host drives the command handshake and waits for the done pulse. A memory arbiter outside the block grants the port.

Operands are 16-bit signed values and products are 32-bit signed words. Addresses are word addresses: consecutive elements sit one address apart. The buffer depth (default 64 elements per vector) is a parameter.

Top module: `vmul_copro`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `done`, `err` and `mem_req` are all 0.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 through the cycle in which `done` is 1, and returns to 1 in the cycle after.
- R3: During the fetch stage the block issues exactly 2n reads (`mem_we` = 0), at most one per granted cycle. It reads addresses src_a+0 … src_a+n-1 first, then src_b+0 … src_b+n-1.
- R4: Each operand is taken from bits [15:0] of `mem_rdata` as a signed value; bits [31:16] have no effect on any result. Read data arrive in issue order, marked by `mem_rvalid`.
- R5: Each product is the full 32-bit two's-complement product of the two signed 16-bit operands, including the case -32768 × -32768 = 2^30.
- R6: During the drain stage the block issues exactly n writes (`mem_we` = 1). Element i goes to address dst+i, in ascending order of i. No word outside dst … dst+n-1 is written.
- R7: No write is requested before all 2n read responses have returned, and no read is requested after the first write of a command.
- R8: A command with `cmd_len` = 0 makes no memory request and raises `done` within 3 cycles of acceptance.
- R9: A `cmd_len` above the buffer depth is processed as exactly the buffer depth. It sets `err` to 1, and `err` stays 1 until reset.
- R10: `done` is high for exactly one cycle per accepted command. It follows the final granted write, or the decode stage when n = 0.
- R11: While `mem_req` is 1 and `mem_gnt` is 0, the next cycle keeps `mem_req` at 1 with `mem_addr`, `mem_we` and `mem_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_src_a | input | AW | Word address of operand vector a |
| cmd_src_b | input | AW | Word address of operand vector b |
| cmd_dst | input | AW | Word address of result vector z |
| cmd_len | input | LW | Requested element count |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag: a count was clamped |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Access taken in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 2*DW | Write data (product) |
| mem_rdata | input | 2*DW | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
In the fetch stage, issuing a new read and taking in an earlier read's data can fall in the same cycle. The bench provokes this with a memory model that answers one cycle after each grant, under three grant patterns: grant always high, grant alternating, and grant from a shift-register pattern. Every issued address is checked against src_a+k, or src_b+(k-n) once k ≥ n. Every product written back is compared with one computed in the bench. A miscount at the a/b boundary would show up in either check. The bench also confirms that the first write only appears once all 2n responses have been counted.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECODE,
      ST_FETCH,
      ST_COMPUTE,
      ST_SETUP,
      ST_DRAIN,
      ST_DONE
   } vmul_stage_e;
endpackage

// File: rtl/vmul_lbuf.sv
module vmul_lbuf #(
   parameter int DW    = 16,
   parameter int DEPTH = 64,
   parameter int IW    = 6
) (
   input  logic                  clk,
   input  logic                  opw_en,
   input  logic                  opw_sel_b,
   input  logic [IW-1:0]         opw_idx,
   input  logic [DW-1:0]         opw_data,
   input  logic [IW-1:0]         op_rd_idx,
   output logic signed [DW-1:0]  op_rd_a,
   output logic signed [DW-1:0]  op_rd_b,
   input  logic                  zw_en,
   input  logic [IW-1:0]         zw_idx,
   input  logic [2*DW-1:0]       zw_data,
   input  logic [IW-1:0]         zr_idx,
   output logic [2*DW-1:0]       zr_data
);
   logic [DW-1:0]   a_q [DEPTH];
   logic [DW-1:0]   b_q [DEPTH];
   logic [2*DW-1:0] z_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (opw_en && !opw_sel_b && opw_idx == IW'(e)) a_q[e] <= opw_data;
         if (opw_en &&  opw_sel_b && opw_idx == IW'(e)) b_q[e] <= opw_data;
         if (zw_en && zw_idx == IW'(e))                 z_q[e] <= zw_data;
      end
   end

   assign op_rd_a = a_q[op_rd_idx];
   assign op_rd_b = b_q[op_rd_idx];
   assign zr_data = z_q[zr_idx];
endmodule

// File: rtl/vmul_mulpipe.sv
module vmul_mulpipe #(
   parameter int DW     = 16,
   parameter int IW     = 6,
   parameter bit SIGNED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [IW-1:0]        in_idx,
   input  logic signed [DW-1:0] in_a,
   input  logic signed [DW-1:0] in_b,
   output logic                 out_valid,
   output logic [IW-1:0]        out_idx,
   output logic [2*DW-1:0]      out_prod
);
   localparam int MW = 2 * DW;
   logic [MW-1:0] prod_d;

   if (SIGNED) begin : g_signed
      logic signed [MW-1:0] sp;
      assign sp     = in_a * in_b;
      assign prod_d = sp;
   end else begin : g_unsigned
      assign prod_d = MW'(unsigned'(in_a)) * MW'(unsigned'(in_b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_prod  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_idx  <= in_idx;
            out_prod <= prod_d;
         end
      end
   end
endmodule

// File: rtl/vmul_agu.sv
module vmul_agu #(
   parameter int AW = 32,
   parameter int CW = 7,
   parameter int FW = 8
) (
   input  logic          drain,
   input  logic [FW-1:0] iss_cnt,
   input  logic [CW-1:0] n_elem,
   input  logic [CW-1:0] wr_idx,
   input  logic [AW-1:0] base_a,
   input  logic [AW-1:0] base_b,
   input  logic [AW-1:0] base_d,
   output logic [AW-1:0] addr
);
   logic          in_b;
   logic [FW-1:0] b_off;

   assign in_b  = iss_cnt >= FW'(n_elem);
   assign b_off = iss_cnt - FW'(n_elem);

   always_comb begin
      if (drain)      addr = base_d + AW'(wr_idx);
      else if (in_b)  addr = base_b + AW'(b_off);
      else            addr = base_a + AW'(iss_cnt);
   end
endmodule

// File: rtl/vmul_copro.sv
module vmul_copro
   import vmul_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 32,
   parameter int LW   = 16,
   parameter int MAXN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [AW-1:0]    cmd_src_a,
   input  logic [AW-1:0]    cmd_src_b,
   input  logic [AW-1:0]    cmd_dst,
   input  logic [LW-1:0]    cmd_len,
   output logic             done,
   output logic             err,
   output logic             mem_req,
   input  logic             mem_gnt,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [2*DW-1:0]  mem_wdata,
   input  logic [2*DW-1:0]  mem_rdata,
   input  logic             mem_rvalid
);
   localparam int MW = 2 * DW;
   localparam int IW = $clog2(MAXN);
   localparam int CW = IW + 1;
   localparam int FW = IW + 2;

   initial begin : g_param_chk
      assert (MAXN >= 2 && (1 << IW) == MAXN) else $error("MAXN must be a power of two >= 2");
      assert (LW > IW) else $error("LW too narrow for MAXN");
      assert (DW >= 2) else $error("DW too small");
   end

   vmul_stage_e   stage_q;
   logic [AW-1:0] base_a_q, base_b_q, base_d_q, wr_base_q;
   logic [LW-1:0] len_q;
   logic [CW-1:0] n_q, idx_q;
   logic [FW-1:0] iss_q, rcv_q, n2;
   logic          err_q;

   logic                 rcv_b;
   logic [FW-1:0]        rcv_off;
   logic signed [DW-1:0] op_a, op_b;
   logic                 mp_in_valid, mp_out_valid;
   logic [IW-1:0]        mp_out_idx;
   logic [MW-1:0]        mp_prod, z_rd;
   logic                 rdata_hi_unused;

   assign n2              = {n_q, 1'b0};
   assign rcv_b           = rcv_q >= FW'(n_q);
   assign rcv_off         = rcv_b ? rcv_q - FW'(n_q) : rcv_q;
   assign mp_in_valid     = (stage_q == ST_COMPUTE) && (idx_q < n_q);
   assign rdata_hi_unused = ^mem_rdata[MW-1:DW];

   vmul_lbuf #(.DW(DW), .DEPTH(MAXN), .IW(IW)) u_lbuf (
      .clk       (clk),
      .opw_en    (stage_q == ST_FETCH && mem_rvalid),
      .opw_sel_b (rcv_b),
      .opw_idx   (IW'(rcv_off)),
      .opw_data  (mem_rdata[DW-1:0]),
      .op_rd_idx (IW'(idx_q)),
      .op_rd_a   (op_a),
      .op_rd_b   (op_b),
      .zw_en     (mp_out_valid),
      .zw_idx    (mp_out_idx),
      .zw_data   (mp_prod),
      .zr_idx    (IW'(idx_q)),
      .zr_data   (z_rd)
   );

   vmul_mulpipe #(.DW(DW), .IW(IW), .SIGNED(1'b1)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mp_in_valid),
      .in_idx    (IW'(idx_q)),
      .in_a      (op_a),
      .in_b      (op_b),
      .out_valid (mp_out_valid),
      .out_idx   (mp_out_idx),
      .out_prod  (mp_prod)
   );

   vmul_agu #(.AW(AW), .CW(CW), .FW(FW)) u_agu (
      .drain   (stage_q == ST_DRAIN),
      .iss_cnt (iss_q),
      .n_elem  (n_q),
      .wr_idx  (idx_q),
      .base_a  (base_a_q),
      .base_b  (base_b_q),
      .base_d  (wr_base_q),
      .addr    (mem_addr)
   );

   assign cmd_ready = (stage_q == ST_IDLE);
   assign done      = (stage_q == ST_DONE);
   assign err       = err_q;
   assign mem_req   = (stage_q == ST_FETCH && iss_q < n2) || (stage_q == ST_DRAIN);
   assign mem_we    = (stage_q == ST_DRAIN);
   assign mem_wdata = z_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= ST_IDLE;
         base_a_q  <= '0;
         base_b_q  <= '0;
         base_d_q  <= '0;
         wr_base_q <= '0;
         len_q     <= '0;
         n_q       <= '0;
         idx_q     <= '0;
         iss_q     <= '0;
         rcv_q     <= '0;
         err_q     <= 1'b0;
      end else begin
         case (stage_q)
            ST_IDLE: if (cmd_valid) begin
               base_a_q <= cmd_src_a;
               base_b_q <= cmd_src_b;
               base_d_q <= cmd_dst;
               len_q    <= cmd_len;
               stage_q  <= ST_DECODE;
            end
            ST_DECODE: begin
               iss_q <= '0;
               rcv_q <= '0;
               idx_q <= '0;
               if (len_q > LW'(MAXN)) begin
                  n_q     <= CW'(MAXN);
                  err_q   <= 1'b1;
                  stage_q <= ST_FETCH;
               end else begin
                  n_q     <= CW'(len_q);
                  stage_q <= (len_q == '0) ? ST_DONE : ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_req && mem_gnt) iss_q <= iss_q + 1'b1;
               if (mem_rvalid) begin
                  rcv_q <= rcv_q + 1'b1;
                  if (rcv_q == n2 - 1'b1) stage_q <= ST_COMPUTE;
               end
            end
            ST_COMPUTE: begin
               if (mp_in_valid) idx_q <= idx_q + 1'b1;
               if (mp_out_valid && mp_out_idx == IW'(n_q - 1'b1)) stage_q <= ST_SETUP;
            end
            ST_SETUP: begin
               wr_base_q <= base_d_q;
               idx_q     <= '0;
               stage_q   <= ST_DRAIN;
            end
            ST_DRAIN: if (mem_gnt) begin
               if (idx_q == n_q - 1'b1) stage_q <= ST_DONE;
               else                     idx_q   <= idx_q + 1'b1;
            end
            default: stage_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vmul_copro_chk.sv
module vmul_copro_chk #(
   parameter int AW = 32,
   parameter int MW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          done,
   input logic          err,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [MW-1:0] mem_wdata
);
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready);                              // R2
   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_ready);                                                // R2
   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready);                                                 // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);                                                        // R9
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !mem_req);                                             // R8
   AST_WRITE_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);                                                 // R6
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));                      // R11
endmodule

bind vmul_copro vmul_copro_chk #(.AW(AW), .MW(MW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .done      (done),
   .err       (err),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/vmul_copro_tb.sv
module vmul_copro_tb;
   localparam int NMAX = 8;
   localparam int A0 = 'h10, B0 = 'h40, D0 = 'h80;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0;
   logic [15:0] cmd_len = '0;
   logic        cmd_ready, done, err, mem_req, mem_we;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

   logic [31:0] mem [256];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   int          gmode = 0;
   logic [7:0]  lfsr = 8'h5B;

   int n_chk = 0, n_fail = 0;
   int exp_n = 0, rd_cnt = 0, wr_cnt = 0, rv_cnt = 0, done_cnt = 0;
   bit busy = 1'b0;
   logic [15:0] ea [NMAX];
   logic [15:0] eb [NMAX];
   logic [31:0] ep [NMAX];

   always #10 clk = ~clk;

   vmul_copro #(.MAXN(NMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
      .done(done), .err(err), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: one-cycle read latency, backdoor load port
   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (gmode)
         0: mem_gnt <= 1'b1;
         1: mem_gnt <= lfsr[0];
         default: mem_gnt <= ~mem_gnt;
      endcase
      if (ld_en) mem[ld_addr] <= ld_data;
      if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rvalid <= mem_req && mem_gnt && !mem_we;
      mem_rdata  <= mem[mem_addr[7:0]];
   end

   // access monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rvalid) rv_cnt++;
         if (done) done_cnt++;
         if (busy && cmd_ready) chk(1'b0, "R2 ready while busy", 1, 0);
         if (mem_req && mem_gnt && !mem_we) begin
            chk(rd_cnt < 2*exp_n && wr_cnt == 0, "R3/R7 read count", rd_cnt, 2*exp_n);
            if (rd_cnt < exp_n) chk(mem_addr == A0 + rd_cnt, "R3 a address", mem_addr, A0 + rd_cnt);
            else chk(mem_addr == B0 + rd_cnt - exp_n, "R3 b address", mem_addr, B0 + rd_cnt - exp_n);
            rd_cnt++;
         end
         if (mem_req && mem_gnt && mem_we) begin
            chk(rv_cnt == 2*exp_n, "R7 write before all reads", rv_cnt, 2*exp_n);
            chk(wr_cnt < exp_n, "R6 write count", wr_cnt, exp_n);
            chk(mem_addr == D0 + wr_cnt, "R6 write address", mem_addr, D0 + wr_cnt);
            if (wr_cnt < exp_n)
               chk(mem_wdata == ep[wr_cnt], "R5 product", mem_wdata, ep[wr_cnt]);
            wr_cnt++;
         end
      end
   end

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk); #2;
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
      @(posedge clk); #2;
      ld_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); #2; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #2; rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready === 1'b1, "R1 ready", cmd_ready, 1);
      chk(done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R1 outputs idle",
          {done, err, mem_req}, 0);
   endtask

   task automatic load_vecs(input int n, input int seed, input bit extreme);
      for (int i = 0; i < NMAX; i++) begin
         logic signed [15:0] a, b;
         a = 16'((i + 1) * 12345 + seed * 777 + (i % 2) * 32768);
         b = 16'(-(i * 3001) - seed * 5 + ((i % 3) == 0 ? 32767 : 0));
         if (extreme) begin
            a = (i % 2 == 0) ? -16'sd32768 : 16'sd32767;
            b = -16'sd32768;
         end
         ea[i] = a; eb[i] = b;
         ep[i] = 32'(int'(a) * int'(b));
         if (i < n) begin
            poke(A0 + i, {16'hA5A5, a});
            poke(B0 + i, {16'h5A5A, b});
         end
      end
      for (int k = D0 - 1; k <= D0 + NMAX + 1; k++) poke(k, 32'hCAFE_0000 + k);
   endtask

   task automatic run_cmd(input int len, input bit exp_err);
      int n, lat;
      n = (len > NMAX) ? NMAX : len;
      exp_n = n; rd_cnt = 0; wr_cnt = 0; rv_cnt = 0; done_cnt = 0;
      @(negedge clk); #2;
      cmd_valid = 1'b1; cmd_src_a = A0; cmd_src_b = B0; cmd_dst = D0; cmd_len = 16'(len);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk); #2;
      cmd_valid = 1'b0; busy = 1'b1;
      lat = 0;
      do begin
         @(negedge clk); lat++;
      end while (!done && lat < 3000);
      chk(done === 1'b1, "R10 done reached", done, 1);
      chk(cmd_ready === 1'b0, "R2 ready low with done", cmd_ready, 0);
      busy = 1'b0;
      if (n == 0) chk(lat <= 3, "R8 zero-length latency", lat, 3);
      @(negedge clk);
      chk(done === 1'b0 && cmd_ready === 1'b1, "R2/R10 after done", {done, cmd_ready}, 2'b01);
      chk(done_cnt == 1, "R10 single pulse", done_cnt, 1);
      chk(rd_cnt == 2*n, "R3 reads issued", rd_cnt, 2*n);
      chk(wr_cnt == n, "R6 writes issued", wr_cnt, n);
      if (n == 0) chk(rd_cnt + wr_cnt == 0, "R8 no access", rd_cnt + wr_cnt, 0);
      for (int i = 0; i < n; i++)
         chk(mem[D0 + i] == ep[i], "R4/R5 stored result", mem[D0 + i], ep[i]);
      chk(mem[D0 - 1] == 32'hCAFE_0000 + D0 - 1, "R6 guard below",
          mem[D0 - 1], 32'hCAFE_0000 + D0 - 1);
      chk(mem[D0 + n] == 32'hCAFE_0000 + D0 + n, "R6 guard above",
          mem[D0 + n], 32'hCAFE_0000 + D0 + n);
      chk(err === exp_err, "R9 error flag", err, exp_err);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      bit seen_big;
      do_reset();
      for (int m = 0; m < 3; m++) begin
         gmode = m;
         do_reset();
         seen_big = 1'b0;
         for (int len = 0; len <= NMAX + 3; len++) begin
            if (len > NMAX) seen_big = 1'b1;
            load_vecs((len > NMAX) ? NMAX : len, len + m, 1'b0);
            run_cmd(len, seen_big);
         end
      end
      gmode = 1;
      do_reset();
      load_vecs(4, 0, 1'b1);
      run_cmd(4, 1'b0);               // R5 extreme operands
      load_vecs(NMAX, 3, 1'b0);
      run_cmd(300, 1'b1);             // R9 clamp far above depth
      load_vecs(2, 9, 1'b0);
      run_cmd(2, 1'b1);               // R9 stays set
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule